// File: doc/BRIEF.md
# Serial-Input Latched Output Driver Core

This block is the logic core of a 32-channel output driver that is loaded serially. A data bit is taken in on each rising edge of the block clock and moves one stage further along a shift chain at every edge. The far end of the chain is brought out as a serial output. Several devices can therefore be wired in a daisy chain and share one clock and one control pair.

A strobe level makes a bank of output latches transparent. While the strobe is high, each latch bit tracks its chain stage, including any shifts that happen during that time. When the strobe drops, the bank keeps what it last saw. A separate blanking level forces all 32 output enables off. Blanking leaves the latch bank unchanged, so the outputs return to the stored pattern as soon as blanking is released. An active-low reset clears both the chain and the latch bank.

Top module: `sid_driver_core`

## Requirements
- R1: On a rising clock edge, the level on `ser_in` is stored in stage 0 of the chain. With strobe high and blanking low, this bit is visible on `drive_en[0]` right after that edge.
- R2: Each rising clock edge moves the content of stage i into stage i+1, for i from 0 to 30. The content of stage 31 is dropped.
- R3: The chain has 32 stages. `ser_out` always shows stage 31 and changes only at rising clock edges. A bit taken in at some edge appears on `ser_out` after the 31st edge that follows it.
- R4: While `strobe` is high, latch bit i equals chain stage i at all times. This includes the cycles in which the chain shifts.
- R5: While `strobe` is low, the latch bank holds the value it had when `strobe` fell, no matter what shifts into the chain.
- R6: While `blank` is high, all 32 bits of `drive_en` are 0, whatever the latch holds.
- R7: Blanking does not change the latch bank. While `blank` is low, `drive_en[i]` equals latch bit i, so an output is on exactly when its latch bit is 1.
- R8: While `rst_n` is low, the chain and the latch bank are cleared to zero. As a result, `ser_out` is 0 and `drive_en` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the chain and the latch bank |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High makes the latch bank transparent to the chain |
| blank | input | 1 | High forces every output enable off |
| ser_out | output | 1 | Stage 31 of the chain, for cascading |
| drive_en | output | 32 | Per-channel output enable; bit i belongs to stage i |

## Verification
The chain is first loaded with single isolated ones and with a full 32-bit word while the strobe stays low. The first pattern shows which stage a bit enters and which way it moves. The second shows that a closed latch ignores the chain, and it gives the exact delay to `ser_out`. Strobe pulses are then issued while the chain keeps shifting, which separates a transparent latch from one loaded on an edge. Blanking is toggled over a non-zero stored pattern to show that the outputs are gated while the stored data is kept. A long seeded random mix of data, strobe and blanking, with a reset in the middle, then compares every cycle against a model of the chain and the latch.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int unsigned SID_DEF_WIDTH = 32;

  typedef enum logic {
    OUT_PASS    = 1'b0,
    OUT_BLANKED = 1'b1
  } sid_out_mode_e;
endpackage

// File: rtl/sid_shift_chain.sv
module sid_shift_chain #(
  parameter int unsigned WIDTH = sid_pkg::SID_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages,
  output logic             tail
);
  localparam int unsigned LAST = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic d_in;
    if (i == 0) begin : g_head
      assign d_in = ser_in;
    end else begin : g_body
      assign d_in = stages[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages[i] <= 1'b0;
      else        stages[i] <= d_in;
    end
  end

  assign tail = stages[LAST];
endmodule

// File: rtl/sid_latch_bank.sv
module sid_latch_bank #(
  parameter int unsigned WIDTH = sid_pkg::SID_DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_latch begin
      if (!rst_n)       q[i] <= 1'b0;
      else if (open_en) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/sid_out_gate.sv
module sid_out_gate #(
  parameter int unsigned WIDTH = sid_pkg::SID_DEF_WIDTH
) (
  input  logic             blank,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] enables
);
  import sid_pkg::*;

  function automatic logic [WIDTH-1:0] gate_fn(input sid_out_mode_e m,
                                               input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    case (m)
      OUT_BLANKED: r = '0;
      default:     r = v;
    endcase
    return r;
  endfunction

  sid_out_mode_e mode;
  assign mode    = blank ? OUT_BLANKED : OUT_PASS;
  assign enables = gate_fn(mode, held);
endmodule

// File: rtl/sid_driver_core.sv
module sid_driver_core #(
  parameter int unsigned WIDTH = sid_pkg::SID_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             strobe,
  input  logic             blank,
  output logic             ser_out,
  output logic [WIDTH-1:0] drive_en
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] latch_q;

  sid_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (ser_in),
    .stages (chain_q),
    .tail   (ser_out)
  );

  sid_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .rst_n   (rst_n),
    .open_en (strobe),
    .d       (chain_q),
    .q       (latch_q)
  );

  sid_out_gate #(.WIDTH(WIDTH)) u_gate (
    .blank   (blank),
    .held    (latch_q),
    .enables (drive_en)
  );
endmodule

// File: rtl/sid_driver_chk.sv
module sid_driver_chk #(
  parameter int unsigned WIDTH = sid_pkg::SID_DEF_WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_in,
  input logic             strobe,
  input logic             blank,
  input logic             ser_out,
  input logic [WIDTH-1:0] drive_en,
  input logic [WIDTH-1:0] chain_q,
  input logic [WIDTH-1:0] latch_q
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (chain_q[0] == $past(ser_in)))
    else $error("p_capture_r1");

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0])))
    else $error("p_advance_r2");

  p_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ser_out == $past(chain_q[WIDTH-2])))
    else $error("p_tail_r3");

  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (latch_q == chain_q))
    else $error("p_follow_r4");

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe) && $past(rst_n)) |-> $stable(latch_q))
    else $error("p_hold_r5");

  p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (drive_en == '0))
    else $error("p_blank_off_r6");

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> (drive_en == latch_q))
    else $error("p_pass_r7");

  p_clear_r8: assert property (@(posedge clk)
    !rst_n |-> (chain_q == '0 && latch_q == '0))
    else $error("p_clear_r8");
endmodule

bind sid_driver_core sid_driver_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .strobe   (strobe),
  .blank    (blank),
  .ser_out  (ser_out),
  .drive_en (drive_en),
  .chain_q  (chain_q),
  .latch_q  (latch_q)
);

// File: tb/sid_driver_core_test.sv
module sid_driver_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_in = 1'b0;
  logic         strobe = 1'b0;
  logic         blank = 1'b0;
  logic         ser_out;
  logic [W-1:0] drive_en;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] m_chain = '0;
  logic [W-1:0] m_latch = '0;

  always #4 clk = ~clk;

  sid_driver_core #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
    .blank(blank), .ser_out(ser_out), .drive_en(drive_en)
  );

  function automatic logic [W-1:0] want_drive(input logic [W-1:0] lat, input logic b);
    if (b) return '0;
    return lat;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string dtag);
    chk(dtag, drive_en, want_drive(m_latch, blank));
    chk("R3 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_chain[W-1]});
  endtask

  function automatic string pick_tag(input logic s, input logic b);
    if (b)      return "R6";
    else if (s) return "R4";
    else        return "R5/R7";
  endfunction

  task automatic step(input logic d, input logic s, input logic b);
    @(negedge clk);
    ser_in = d; strobe = s; blank = b;
    #1;
    if (s) m_latch = m_chain;
    compare_all(pick_tag(s, b));
    @(posedge clk);
    #1;
    m_chain = {m_chain[W-2:0], d};
    if (s) m_latch = m_chain;
    compare_all(pick_tag(s, b));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ser_in = 1'b1; strobe = 1'b1; blank = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_chain = '0; m_latch = '0;
    chk("R8 drive_en", drive_en, '0);
    chk("R8 ser_out", {{(W-1){1'b0}}, ser_out}, '0);
    @(negedge clk);
    rst_n = 1'b1; ser_in = 1'b0; strobe = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: single one enters stage 0, visible on drive_en[0]
    step(1'b1, 1'b1, 1'b0);
    chk("R1", drive_en, 32'h0000_0001);
    // R2: it moves toward the tail
    step(1'b0, 1'b1, 1'b0);
    chk("R2", drive_en, 32'h0000_0002);
    step(1'b0, 1'b1, 1'b0);
    chk("R2", drive_en, 32'h0000_0004);

    // R5: latch closed while a full word shifts in
    word = 32'hA5C3_0F71;
    for (int i = W - 1; i >= 0; i--) step(word[i], 1'b0, 1'b0);
    chk("R5 held", drive_en, 32'h0000_0004);
    // R4: strobe opens latch onto the chain
    step(1'b0, 1'b1, 1'b0);
    chk("R4 word", drive_en, {word[W-2:0], 1'b0});
    // R6 / R7: blanking gates without losing data
    step(1'b1, 1'b0, 1'b1);
    chk("R6", drive_en, '0);
    step(1'b1, 1'b0, 1'b0);
    chk("R7 restore", drive_en, {word[W-2:0], 1'b0});

    // R3: a marked bit reaches ser_out after 31 further edges
    do_reset();
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < W - 2; i++) step(1'b0, 1'b0, 1'b0);
    chk("R3 not yet", {{(W-1){1'b0}}, ser_out}, '0);
    step(1'b0, 1'b0, 1'b0);
    chk("R3 arrived", {{(W-1){1'b0}}, ser_out}, 32'h1);

    // random mix with a mid-run reset
    for (int n = 0; n < 3000; n++) begin
      if (n == 1500) do_reset();
      step(1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule